// File: doc/BRIEF.md
# DDR3 Read/Write Command Spacing Controller

This block sits between a requester of column accesses and a DDR3-style command bus. The requester offers one READ or WRITE at a time over a valid/ready handshake. Each request carries a bank, a column, an auto-precharge flag and a chop bit that selects an eight-beat burst or a four-beat chopped burst. The controller releases a request only once the minimum spacing from the earlier commands has elapsed. It then drives the command for one clock, with the decoded beat count. From the static latency inputs it also marks the clocks on which read data and write data occupy the data bus.

The column-to-column delay is fixed at four clocks and applies between any two commands. A READ followed by a WRITE needs the larger of that delay and CL + 4 − CWL + 2 clocks. Read latency equals CL because additive latency must be zero, and write latency equals CWL for the same reason. Bursts are never cut short: a chopped burst still occupies a full four-clock slot, so back-to-back chopped reads leave a two-clock hole on the bus. Back-pressure is plain. While `req_ready` is low the requester keeps `req_valid` high and the payload unchanged. `req_ready` may depend on `req_is_write`, because the spacing depends on the type of command offered. An illegal latency setting raises a sticky error and stops all issue until reset.

Top module: `ddr_cmdsp_ctrl`

## Requirements
- R1: After reset, with a legal configuration, `cmd_fire`, `rd_bus_busy`, `wr_bus_busy` and `cfg_err` are 0 and `req_ready` is 1. The first request is accepted on the cycle it is offered.
- R2: A request accepted at a rising edge produces `cmd_fire` = 1 for exactly the following cycle. In that cycle the type, bank, column and auto-precharge flag are copied unchanged to the `cmd_*` outputs. Every `cmd_fire` pulse matches exactly one accepted request.
- R3: `cmd_beats` is 8 when `req_chop` was 0 and 4 when `req_chop` was 1.
- R4: Two consecutive accepted requests are at least 4 cycles apart for read→read, write→write and write→read. A request waiting on that bound is accepted exactly when the bound is reached.
- R5: A WRITE that follows a READ is accepted no earlier than max(4, CL + 6 − CWL) cycles after the READ, and exactly then if it is already waiting.
- R6: If `cmd_fire` for a READ is high in cycle c, `rd_bus_busy` is high in cycles c+CL through c+CL+3 for an 8-beat burst, or c+CL through c+CL+1 for a 4-beat burst, and low otherwise. Eight-beat reads spaced 4 cycles apart keep it high without a break.
- R7: Two 4-beat reads spaced 4 cycles apart leave `rd_bus_busy` low in cycles c+CL+2 and c+CL+3 between them.
- R8: `wr_bus_busy` follows the R6 rule for WRITE commands, with CWL in place of CL.
- R9: If `cfg_al` ≠ 0, `cfg_cl` = 0 or `cfg_cwl` = 0, `req_ready` drops in the same cycle. `cfg_err` rises on the next cycle and stays high until reset, even if the configuration is corrected, and no command issues while it is high.
- R10: While `req_ready` is low the request is held and not issued. Holding it causes no extra `cmd_fire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | 4 | Additive latency; must be 0 |
| cfg_cl | input | 4 | CAS read latency in clocks |
| cfg_cwl | input | 4 | CAS write latency in clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_is_write | input | 1 | 1 = WRITE, 0 = READ |
| req_chop | input | 1 | 1 = 4-beat chopped burst, 0 = 8-beat burst |
| req_autopre | input | 1 | Close the row at the end of the burst |
| req_bank | input | 3 | Bank address |
| req_col | input | 10 | Column address |
| cmd_fire | output | 1 | Command driven this cycle |
| cmd_is_write | output | 1 | Type of the driven command |
| cmd_autopre | output | 1 | Auto-precharge flag of the driven command |
| cmd_bank | output | 3 | Bank of the driven command |
| cmd_col | output | 10 | Column of the driven command |
| cmd_beats | output | 4 | Beats in the burst, 8 or 4 |
| rd_bus_busy | output | 1 | Read data on the data bus this cycle |
| wr_bus_busy | output | 1 | Write data on the data bus this cycle |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The assertions assume the requester obeys the hold rule: once it offers a request that is not yet taken, it keeps `req_valid` high, at least until a configuration error has latched. They also assume the latency inputs change only while no burst is pending. The stimulus offers each request at a falling edge and holds it until `req_ready` is seen high. It changes latencies only after the data bus has drained. Before it drops the request in the error phase, it holds that request for several cycles so that `cfg_err` has already latched.

// File: rtl/ddr_cmdsp_pkg.sv
package ddr_cmdsp_pkg;
  localparam int CCD        = 4;
  localparam int RTW_EXTRA  = 2;
  localparam int BEATS_FULL = 8;
  localparam int BEATS_CHOP = 4;
  localparam int CLK_FULL   = 4;
  localparam int CLK_CHOP   = 2;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;
endpackage

// File: rtl/ddr_cmdsp_cfg_chk.sv
module ddr_cmdsp_cfg_chk #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] al,
  input  logic [LAT_W-1:0] cl,
  input  logic [LAT_W-1:0] cwl,
  output logic             cfg_bad,
  output logic             cfg_err
);
  assign cfg_bad = (al != '0) || (cl == '0) || (cwl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_err | cfg_bad;
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: rtl/ddr_cmdsp_gap.sv
module ddr_cmdsp_gap
  import ddr_cmdsp_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             req_wr,
  input  logic [LAT_W-1:0] cl,
  input  logic [LAT_W-1:0] cwl,
  output logic             spacing_ok
);
  localparam int GAP_W = LAT_W + 3;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap_q;
  op_e              last_op_q;
  logic [GAP_W-1:0] rtw_sum, cwl_ccd, rtw_need, need;

  always_comb begin
    rtw_sum  = GAP_W'(cl) + GAP_W'(CCD + RTW_EXTRA);
    cwl_ccd  = GAP_W'(cwl) + GAP_W'(CCD);
    rtw_need = (rtw_sum > cwl_ccd) ? (rtw_sum - GAP_W'(cwl)) : GAP_W'(CCD);
    need     = (last_op_q == OP_RD && req_wr) ? rtw_need : GAP_W'(CCD);
  end

  assign spacing_ok = (gap_q >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= GAP_MAX;
      last_op_q <= OP_WR;
    end else if (fire) begin
      gap_q     <= GAP_W'(1);
      last_op_q <= req_wr ? OP_WR : OP_RD;
    end else if (gap_q != GAP_MAX) begin
      gap_q     <= gap_q + GAP_W'(1);
    end
  end
endmodule

// File: rtl/ddr_cmdsp_sched.sv
module ddr_cmdsp_sched
  import ddr_cmdsp_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             chop,
  input  logic [LAT_W-1:0] lat,
  output logic             busy
);
  localparam int DEPTH = (1 << LAT_W) + CLK_FULL;

  logic [DEPTH-1:0] slot_q, mask;

  always_comb begin
    int len;
    len = chop ? CLK_CHOP : CLK_FULL;
    for (int k = 0; k < DEPTH; k++)
      mask[k] = (k >= int'(lat)) && (k < int'(lat) + len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= (slot_q >> 1) | (load ? mask : '0);
  end

  assign busy = slot_q[0];
endmodule

// File: rtl/ddr_cmdsp_ctrl.sv
module ddr_cmdsp_ctrl
  import ddr_cmdsp_pkg::*;
#(
  parameter int LAT_W  = 4,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic [LAT_W-1:0]  cfg_cl,
  input  logic [LAT_W-1:0]  cfg_cwl,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic              req_chop,
  input  logic              req_autopre,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_fire,
  output logic              cmd_is_write,
  output logic              cmd_autopre,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic [3:0]        cmd_beats,
  output logic              rd_bus_busy,
  output logic              wr_bus_busy,
  output logic              cfg_err
);
  logic cfg_bad, spacing_ok, fire;
  logic [1:0] ch_busy;

  ddr_cmdsp_cfg_chk #(.LAT_W(LAT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .al(cfg_al), .cl(cfg_cl), .cwl(cfg_cwl),
    .cfg_bad(cfg_bad), .cfg_err(cfg_err)
  );

  ddr_cmdsp_gap #(.LAT_W(LAT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .fire(fire), .req_wr(req_is_write),
    .cl(cfg_cl), .cwl(cfg_cwl), .spacing_ok(spacing_ok)
  );

  assign req_ready = spacing_ok && !cfg_err && !cfg_bad;
  assign fire      = req_valid && req_ready;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    ddr_cmdsp_sched #(.LAT_W(LAT_W)) u_sched (
      .clk(clk), .rst_n(rst_n),
      .load(fire && (req_is_write == (g == 1))),
      .chop(req_chop),
      .lat((g == 1) ? cfg_cwl : cfg_cl),
      .busy(ch_busy[g])
    );
  end

  assign rd_bus_busy = ch_busy[0];
  assign wr_bus_busy = ch_busy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_fire     <= 1'b0;
      cmd_is_write <= 1'b0;
      cmd_autopre  <= 1'b0;
      cmd_bank     <= '0;
      cmd_col      <= '0;
      cmd_beats    <= '0;
    end else begin
      cmd_fire <= fire;
      if (fire) begin
        cmd_is_write <= req_is_write;
        cmd_autopre  <= req_autopre;
        cmd_bank     <= req_bank;
        cmd_col      <= req_col;
        cmd_beats    <= req_chop ? 4'(BEATS_CHOP) : 4'(BEATS_FULL);
      end
    end
  end

  p_issue_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_fire);

  p_beats_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (cmd_beats == 4'd8 || cmd_beats == 4'd4));

  p_ccd_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (!$past(cmd_fire, 1) && !$past(cmd_fire, 2) && !$past(cmd_fire, 3)));

  p_no_ready_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !req_ready);

  p_hold_request_r10: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    (req_valid && !req_ready) |=> req_valid);
endmodule

// File: tb/ddr_cmdsp_ctrl_bench.sv
module ddr_cmdsp_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_al = 4'd0, cfg_cl = 4'd6, cfg_cwl = 4'd5;
  logic req_valid = 1'b0, req_is_write = 1'b0, req_chop = 1'b0, req_autopre = 1'b0;
  logic [2:0] req_bank = '0;
  logic [9:0] req_col = '0;
  logic req_ready, cmd_fire, cmd_is_write, cmd_autopre, rd_bus_busy, wr_bus_busy, cfg_err;
  logic [2:0] cmd_bank;
  logic [9:0] cmd_col;
  logic [3:0] cmd_beats;

  always #5 clk = ~clk;

  ddr_cmdsp_ctrl u_ddr_cmdsp_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
    .req_chop(req_chop), .req_autopre(req_autopre), .req_bank(req_bank), .req_col(req_col),
    .cmd_fire(cmd_fire), .cmd_is_write(cmd_is_write), .cmd_autopre(cmd_autopre),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_beats(cmd_beats),
    .rd_bus_busy(rd_bus_busy), .wr_bus_busy(wr_bus_busy), .cfg_err(cfg_err)
  );

  typedef struct {
    bit wr; bit ap; int bank; int col; int beats; int fire_cyc;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit exp_rd[256];
  bit exp_wr[256];
  int last_hs = -100, last_rd_hs = -100;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Monitor: pops the scoreboard on every command and models the data bus.
  always @(negedge clk) begin
    if (mon_on) begin
      chk(rd_bus_busy == exp_rd[cyc % 256], "R6 read bus occupancy", rd_bus_busy, exp_rd[cyc % 256]);
      chk(wr_bus_busy == exp_wr[cyc % 256], "R8 write bus occupancy", wr_bus_busy, exp_wr[cyc % 256]);
      exp_rd[cyc % 256] = 1'b0;
      exp_wr[cyc % 256] = 1'b0;
      if (cmd_fire) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R2 unexpected command (R10 hold)", 1, 0);
        end else begin
          exp_t e;
          int len;
          e = sbq.pop_front();
          chk(cyc == e.fire_cyc, "R2 issue cycle", cyc, e.fire_cyc);
          chk(cmd_is_write == e.wr, "R2 command type", cmd_is_write, e.wr);
          chk(cmd_autopre == e.ap, "R2 auto-precharge flag", cmd_autopre, e.ap);
          chk(int'(cmd_bank) == e.bank, "R2 bank", cmd_bank, e.bank);
          chk(int'(cmd_col) == e.col, "R2 column", cmd_col, e.col);
          chk(int'(cmd_beats) == e.beats, "R3 beat count", cmd_beats, e.beats);
          len = (e.beats == 8) ? 4 : 2;
          for (int k = 0; k < len; k++) begin
            if (e.wr) exp_wr[(cyc + int'(cfg_cwl) + k) % 256] = 1'b1;
            else      exp_rd[(cyc + int'(cfg_cl) + k) % 256] = 1'b1;
          end
        end
      end
    end
  end

  // Driver: offers a request, predicts its acceptance cycle, pushes the expected command.
  task automatic send(input bit wr, input bit chop, input bit ap, input int bank, input int col,
                      output int fire_at);
    int start, hs_exp, rtw;
    exp_t e;
    @(negedge clk);
    req_is_write = wr; req_chop = chop; req_autopre = ap;
    req_bank = 3'(bank); req_col = 10'(col); req_valid = 1'b1;
    start = cyc;
    rtw = imax(4, int'(cfg_cl) + 6 - int'(cfg_cwl));
    hs_exp = imax(start, last_hs + 4);
    if (wr) hs_exp = imax(hs_exp, last_rd_hs + rtw);
    #1;
    if (hs_exp > start)
      chk(req_ready == 1'b0, "R10 ready low while spacing pending", req_ready, 0);
    while (!req_ready) @(negedge clk);
    chk(cyc == hs_exp, wr ? "R5 R4 acceptance cycle" : "R4 acceptance cycle", cyc, hs_exp);
    e.wr = wr; e.ap = ap; e.bank = bank; e.col = col;
    e.beats = chop ? 4 : 8; e.fire_cyc = cyc + 1;
    sbq.push_back(e);
    last_hs = cyc;
    if (!wr) last_rd_hs = cyc;
    fire_at = cyc + 1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    int f, f1, f2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cmd_fire == 1'b0, "R1 cmd_fire after reset", cmd_fire, 0);
    chk(rd_bus_busy == 1'b0 && wr_bus_busy == 1'b0, "R1 bus idle after reset", rd_bus_busy | wr_bus_busy, 0);
    chk(cfg_err == 1'b0, "R1 no error after reset", cfg_err, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    mon_on = 1'b1;

    // R4/R6: three 8-beat reads, seamless data
    send(1'b0, 1'b0, 1'b0, 1, 16, f);
    send(1'b0, 1'b0, 1'b1, 2, 24, f);
    send(1'b0, 1'b0, 1'b0, 3, 32, f);
    idle(20);

    // R7: two chopped reads leave a hole
    send(1'b0, 1'b1, 1'b0, 4, 40, f1);
    send(1'b0, 1'b1, 1'b1, 5, 48, f2);
    while (cyc < f1 + int'(cfg_cl) + 1) @(negedge clk);
    chk(rd_bus_busy == 1'b1, "R7 last chopped beat", rd_bus_busy, 1);
    @(negedge clk);
    chk(rd_bus_busy == 1'b0, "R7 bus hole between chopped reads", rd_bus_busy, 0);
    @(negedge clk);
    chk(rd_bus_busy == 1'b0, "R7 bus hole second cycle", rd_bus_busy, 0);
    idle(20);

    // R5: read then write, CL=6 CWL=5 -> 7 cycles; then R4 write-write and write-read
    send(1'b0, 1'b0, 1'b0, 6, 56, f);
    send(1'b1, 1'b0, 1'b1, 7, 64, f);
    send(1'b1, 1'b1, 1'b0, 0, 72, f);
    send(1'b0, 1'b0, 1'b0, 1, 80, f);
    idle(30);

    // R5 clamp: CL=5 CWL=9 -> formula below 4, spacing stays 4
    cfg_cl = 4'd5; cfg_cwl = 4'd9;
    send(1'b0, 1'b1, 1'b0, 2, 88, f);
    send(1'b1, 1'b0, 1'b0, 3, 96, f);
    idle(30);

    // R1/R4: request after a long idle is taken at once
    send(1'b1, 1'b0, 1'b1, 4, 1023, f);
    idle(30);

    // R9: illegal additive latency
    @(negedge clk);
    req_is_write = 1'b1; req_valid = 1'b1; cfg_al = 4'd1;
    #1;
    chk(req_ready == 1'b0, "R9 ready drops on bad config", req_ready, 0);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R9 error latched", cfg_err, 1);
    cfg_al = 4'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(cfg_err == 1'b1, "R9 error sticky", cfg_err, 1);
      chk(req_ready == 1'b0, "R9 issue blocked", req_ready, 0);
    end
    req_valid = 1'b0;
    idle(10);
    chk(sbq.size() == 0, "R2 all commands issued", sbq.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule